// File: doc/BRIEF.md
# Target Read Prefetch Controller

This block decides when the target side of an external bus interface fetches whole lines from local memory ahead of an external master's read. It is used for burst reads. When a read transaction is decoded, the block looks at the command type, the address window that was hit and two control bits: a prefetch enable and a sticky invalidate. If the read qualifies, it issues line requests toward the internal bus. It keeps streaming line after line while the master holds its frame signal and the read buffer still reports free slots.

Each completed line is tagged as valid or as invalid for the buffer logic. A buffer-flush pulse discards prefetched data when the frame ends or when the invalidate bit rises. If the invalidate bit rises while prefetched data is being returned to the external master, the block also asks for a disconnect of that transaction. Buffer storage and the internal bus protocol are handled elsewhere. The block only produces the request and its line-aligned address and consumes a completion strobe.

Top module: `rd_prefetch_ctl`

## Requirements
- R1: While reset is held, and in the cycle after it, `line_req`, `fill_valid`, `fill_inval`, `buf_flush` and `disconnect` are all low.
- R2: Command code 2'b00 (plain read) and 2'b01 (read line) start a prefetch only when `pf_enable` is high and `rd_win` is in 1..5 (prefetchable windows). Window 0 (non-prefetchable memory) and codes 6..7 (no hit) never start one for these commands.
- R3: Command code 2'b10 (read multiple) starts a prefetch in any memory window 0..5 even when `pf_enable` is low. It never starts one for `rd_win` 6..7. Code 2'b11 (not a memory read) never starts a prefetch.
- R4: A qualifying `rd_start` with `frame` high and `buf_free` nonzero raises `line_req` after the next clock edge. `line_req` stays high until `line_ack`. After each completion, the line address steps by one line and the next request rises two edges later if `frame` is still high and `buf_free` is nonzero. While `buf_free` is zero, no request is made.
- R5: When `frame` drops while a prefetch is active, `buf_flush` pulses high for one cycle and streaming stops. A line still in flight completes with `fill_inval` instead of `fill_valid`.
- R6: A rising edge of the sampled `inval_set` pulses `buf_flush` for one cycle after the edge where it is first seen high.
- R7: When `inval_set` rises while `tgt_xfer` is high, `disconnect` pulses for one cycle, together with `buf_flush`. It does not pulse when `tgt_xfer` is low.
- R8: A line whose fetch is in flight when `inval_set` is seen high completes with `fill_inval`, even if the bit was cleared again before the completion.
- R9: While `inval_set` is high, no command code and no window starts a prefetch, including read multiple.
- R10: `line_addr` is the start address with its low `LINE_LOG2` bits cleared, so it is always line-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_enable | input | 1 | Prefetch enable control bit |
| inval_set | input | 1 | Sticky invalidate-and-disable control bit |
| rd_start | input | 1 | One-cycle strobe: a new target read was decoded |
| rd_cmd | input | 2 | 00 read, 01 read line, 10 read multiple, 11 other |
| rd_win | input | 3 | Window hit: 0 non-prefetchable, 1..5 prefetchable, 6..7 none |
| rd_addr | input | AW | Start byte address of the read |
| frame | input | 1 | Master frame asserted (active high) |
| buf_free | input | LVL_W | Free line slots in the target read buffer |
| tgt_xfer | input | 1 | Prefetched data is being returned on the external bus |
| line_ack | input | 1 | Internal bus completed the requested line |
| line_req | output | 1 | Line fetch request toward the internal bus |
| line_addr | output | AW | Line-aligned address of the requested line |
| fill_valid | output | 1 | Completed line is valid |
| fill_inval | output | 1 | Completed line must be treated as invalid |
| buf_flush | output | 1 | Discard all prefetched lines |
| disconnect | output | 1 | Stop the current external transaction |

## Verification
The bench targets the qualifying rules. A design that wrongly applies the enable bit to read multiple would stay silent with the enable clear. One that ignores the window would prefetch from window 0 or on a window miss. A bounded-buffer scenario holds `buf_free` at zero between lines: a controller that streams without looking at space would request anyway. The invalidate cases pulse the bit briefly during a fetch and then clear it. A design without a per-line poison flag would report that line valid. The bench also holds the bit high and tries every command, which exposes any path that bypasses the sticky inhibit. A frame drop in mid-fetch checks that both the flush pulse and the invalid tag on the late line appear.

// File: rtl/rd_prefetch_ctl.sv
module rd_prefetch_ctl #(
  parameter int AW        = 32,
  parameter int LINE_LOG2 = 5,
  parameter int LVL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_enable,
  input  logic             inval_set,
  input  logic             rd_start,
  input  logic [1:0]       rd_cmd,
  input  logic [2:0]       rd_win,
  input  logic [AW-1:0]    rd_addr,
  input  logic             frame,
  input  logic [LVL_W-1:0] buf_free,
  input  logic             tgt_xfer,
  input  logic             line_ack,
  output logic             line_req,
  output logic [AW-1:0]    line_addr,
  output logic             fill_valid,
  output logic             fill_inval,
  output logic             buf_flush,
  output logic             disconnect
);
  localparam logic [AW-1:0] LINE_BYTES = AW'(1) << LINE_LOG2;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK} st_t;
  st_t  state;
  logic inval_q, pf_act, poison;

  wire win_pf   = (rd_win >= 3'd1) && (rd_win <= 3'd5);
  wire win_mem  = (rd_win <= 3'd5);
  wire cmd_rd   = (rd_cmd == 2'b00) || (rd_cmd == 2'b01);
  wire cmd_mrm  = (rd_cmd == 2'b10);
  wire qualify  = (cmd_mrm && win_mem) || (pf_enable && cmd_rd && win_pf);
  wire space    = (buf_free != '0);
  wire inv_rise = inval_set && !inval_q;
  wire drop     = pf_act && !frame;
  wire taint    = poison || inval_set || !frame;

  assign line_req = (state == S_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      inval_q    <= 1'b0;
      pf_act     <= 1'b0;
      poison     <= 1'b0;
      line_addr  <= '0;
      fill_valid <= 1'b0;
      fill_inval <= 1'b0;
      buf_flush  <= 1'b0;
      disconnect <= 1'b0;
    end else begin
      inval_q    <= inval_set;
      buf_flush  <= inv_rise || drop;
      disconnect <= inv_rise && tgt_xfer;
      fill_valid <= 1'b0;
      fill_inval <= 1'b0;
      if (inv_rise || drop) pf_act <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rd_start && frame && qualify && !inval_set && space) begin
            state     <= S_FETCH;
            pf_act    <= 1'b1;
            poison    <= 1'b0;
            line_addr <= {rd_addr[AW-1:LINE_LOG2], {LINE_LOG2{1'b0}}};
          end
        end
        S_FETCH: begin
          if (line_ack) begin
            fill_valid <= !taint;
            fill_inval <= taint;
            line_addr  <= line_addr + LINE_BYTES;
            state      <= S_CHECK;
          end else if (inval_set || !frame) begin
            poison <= 1'b1;
          end
        end
        S_CHECK: begin
          if (!frame || inval_set) begin
            state <= S_IDLE;
          end else if (space) begin
            state  <= S_FETCH;
            poison <= 1'b0;
            pf_act <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: outputs quiet in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !(line_req || fill_valid || fill_inval || buf_flush || disconnect));

  // R4: request held until the internal bus completes it
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && !line_ack) |=> line_req);

  // R4: each completion advances the address by one line
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && line_ack) |=> (line_addr == $past(line_addr) + LINE_BYTES));

  // R4: no new request while the buffer is full
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_req && buf_free == '0) |=> !line_req);

  // R8: a completion is tagged exactly one way
  a_r8_tag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_inval));

  // R7: a disconnect always comes with a flush
  a_r7_disc_flush: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> buf_flush);

  // R9: sticky invalidate blocks any new request
  a_r9_sticky_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_req && inval_set) |=> !line_req);

  // R10: line address is aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    line_addr[LINE_LOG2-1:0] == '0);
endmodule

// File: tb/sim_rd_prefetch_ctl.sv
`timescale 1ns/1ps
module sim_rd_prefetch_ctl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, pf_enable, inval_set, rd_start, frame, tgt_xfer, line_ack;
  logic [1:0]  rd_cmd;
  logic [2:0]  rd_win;
  logic [31:0] rd_addr, line_addr;
  logic [3:0]  buf_free;
  logic        line_req, fill_valid, fill_inval, buf_flush, disconnect;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  rd_prefetch_ctl u0 (
    .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .inval_set(inval_set),
    .rd_start(rd_start), .rd_cmd(rd_cmd), .rd_win(rd_win), .rd_addr(rd_addr),
    .frame(frame), .buf_free(buf_free), .tgt_xfer(tgt_xfer), .line_ack(line_ack),
    .line_req(line_req), .line_addr(line_addr), .fill_valid(fill_valid),
    .fill_inval(fill_inval), .buf_flush(buf_flush), .disconnect(disconnect));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(logic [1:0] c, logic [2:0] w, logic [31:0] a);
    rd_cmd = c; rd_win = w; rd_addr = a; frame = 1'b1; rd_start = 1'b1;
    tick();
    rd_start = 1'b0;
  endtask

  task automatic ack();
    line_ack = 1'b1; tick(); line_ack = 1'b0;
  endtask

  task automatic end_tx();
    frame = 1'b0;
    line_ack = line_req;
    tick();
    line_ack = 1'b0;
    tick(); tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pf_enable = 0; inval_set = 0; rd_start = 0; frame = 0;
    tgt_xfer = 0; line_ack = 0; rd_cmd = 0; rd_win = 0; rd_addr = 0; buf_free = 4;
    repeat (3) tick();
    chk("R1 outputs in reset", {line_req, fill_valid, fill_inval, buf_flush, disconnect}, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after reset", {line_req, fill_valid, fill_inval, buf_flush, disconnect}, 0);
  endtask

  task automatic t_enable_rules();
    pf_enable = 1; buf_free = 4;
    start(2'b00, 3'd1, 32'h0000_1234);
    chk("R2 read win1 enabled req", line_req, 1);
    chk("R10 aligned start address", line_addr, 32'h0000_1220);
    end_tx();
    start(2'b01, 3'd5, 32'h0000_8000);
    chk("R2 read line win5 req", line_req, 1);
    end_tx();
    start(2'b00, 3'd0, 32'h0000_8000);
    chk("R2 window 0 no req", line_req, 0);
    end_tx();
    start(2'b01, 3'd6, 32'h0000_8000);
    chk("R2 window miss no req", line_req, 0);
    end_tx();
    pf_enable = 0;
    start(2'b00, 3'd2, 32'h0000_8000);
    chk("R2 enable clear no req", line_req, 0);
    end_tx();
  endtask

  task automatic t_multiple();
    pf_enable = 0; buf_free = 4;
    start(2'b10, 3'd0, 32'h0000_4000);
    chk("R3 read multiple with enable clear", line_req, 1);
    end_tx();
    start(2'b10, 3'd7, 32'h0000_4000);
    chk("R3 read multiple window miss", line_req, 0);
    end_tx();
    pf_enable = 1;
    start(2'b11, 3'd1, 32'h0000_4000);
    chk("R3 non-read command", line_req, 0);
    end_tx();
  endtask

  task automatic t_stream();
    pf_enable = 1; buf_free = 0;
    start(2'b00, 3'd3, 32'h0000_0100);
    chk("R4 no req when buffer full", line_req, 0);
    end_tx();
    buf_free = 1;
    start(2'b00, 3'd3, 32'h0000_0104);
    chk("R4 first req", line_req, 1);
    buf_free = 0;
    ack();
    chk("R4 fill valid", fill_valid, 1);
    chk("R4 address stepped", line_addr, 32'h0000_0120);
    chk("R4 req low after ack", line_req, 0);
    tick(); tick();
    chk("R4 waits while full", line_req, 0);
    buf_free = 2;
    tick();
    chk("R4 resumes with space", line_req, 1);
    ack();
    tick();
    chk("R4 next line requested", line_req, 1);
    chk("R4 second step", line_addr, 32'h0000_0140);
    frame = 0;
    tick();
    chk("R5 flush on frame drop", buf_flush, 1);
    ack();
    chk("R5 in-flight line invalid", fill_inval, 1);
    chk("R5 in-flight line not valid", fill_valid, 0);
    tick();
    chk("R5 flush single cycle", buf_flush, 0);
    chk("R5 streaming stopped", line_req, 0);
    tick();
  endtask

  task automatic t_invalidate();
    pf_enable = 1; buf_free = 4; tgt_xfer = 0;
    start(2'b00, 3'd1, 32'h0000_2000);
    inval_set = 1;
    tick();
    chk("R6 flush on invalidate", buf_flush, 1);
    chk("R7 no disconnect without transfer", disconnect, 0);
    inval_set = 0;
    tick();
    chk("R6 flush single cycle", buf_flush, 0);
    ack();
    chk("R8 cleared bit still taints line", fill_inval, 1);
    end_tx();
    tgt_xfer = 1;
    start(2'b10, 3'd2, 32'h0000_3000);
    inval_set = 1;
    tick();
    chk("R7 disconnect during transfer", disconnect, 1);
    tick();
    chk("R7 disconnect single cycle", disconnect, 0);
    ack();
    chk("R8 line invalid", fill_inval, 1);
    tgt_xfer = 0;
    end_tx();
    for (int c = 0; c < 3; c++) begin
      start(2'(c), 3'd1, 32'h0000_5000);
      tick();
      chk("R9 sticky blocks prefetch", line_req, 0);
      end_tx();
    end
    inval_set = 0;
    tick();
    start(2'b10, 3'd1, 32'h0000_5000);
    chk("R9 prefetch after clear", line_req, 1);
    end_tx();
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable_rules();
    t_multiple();
    t_stream();
    t_invalidate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule